// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block translates 64-bit virtual addresses to 41-bit physical addresses through a 64-entry fully associative buffer. Each entry carries a virtual page number and a 13-bit context. It also carries a physical page number, a 2-bit page-size code and several attribute bits: valid, global, privileged, writable, side-effect and no-fault-only. The page-size code of each entry sets how many low address bits that entry ignores when it compares addresses and when it forms the physical address. Entries of 8 KB, 64 KB, 512 KB and 4 MB can therefore share the array.

A lookup gives an address, an access kind, a user flag and a context selector. One cycle later the block returns exactly one of four results: hit, fault, protection or miss. The block also holds a fault status register, a fault address register and a tag-access register. Software or a refill engine reads these after a fault or a miss. Entries are loaded through a fill port with an explicit index. When translation is disabled, every lookup hits and passes the address straight through.

Top module: `tlb_xlate`

## Requirements
- R1: The page-size code (0, 1, 2, 3) selects 8 KB, 64 KB, 512 KB or 4 MB. The compare mask ignores the low 13, 16, 19 or 22 address bits. The physical address is made of three parts: the entry's physical bits above the mask, the virtual bits below it, and bits 12:0 cleared.
- R2: An entry hits only when all three hold: it is valid, its virtual page number equals the request's above the mask, and it is either global or its context equals the selected context. Otherwise the result is a miss.
- R3: The context selector chooses the context: 0 selects `pri_ctx`, 1 selects `sec_ctx`, and 2 or 3 select context 0 (nucleus).
- R4: When several entries hit, the lowest-numbered one supplies the result.
- R5: A hit raises a fault in three cases, each with its own status bit, and several bits may be set together. The cases are: a user access to a privileged entry; a no-fault load (kind 2) to a side-effect entry; a load (kind 0) or store (kind 1) to a no-fault-only entry.
- R6: A store to an entry without write permission gives the protection result. This applies only when none of the R5 faults is present; otherwise the result is a fault.
- R7: On a fault or protection result, `fsr_o` is loaded with fresh values in these bits: bit0 valid=1; bit1 overflow=previous valid; bit2 = `priv_mode`; bits 4:3 = context kind (0 primary, 1 secondary, 2 nucleus); bit5 = store; bit6 = no-fault load; bit7 = privilege violation; bit8 = side-effect violation; bit9 = no-fault-only violation. `far_o` captures the full request address.
- R8: On a fault, protection or miss, `tagacc_o` is loaded with the request address with bits 12:0 replaced by the selected context. A miss leaves `fsr_o` and `far_o` unchanged.
- R9: A hit without fault or protection sets the entry's used bit, and `rsp_was_used` reports the value of that bit before the lookup. A fill clears the used bit.
- R10: With `xlat_en` low, every lookup hits with `rsp_pa` equal to the request address bits 40:0 and `rsp_wr_ok`=1. No register is updated in this case.
- R11: A response appears exactly one cycle after a request, with exactly one of hit, fault, protection or miss set. `rsp_valid` stays low when there is no request. Reset invalidates all entries and clears all three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable |
| priv_mode | input | 1 | Current privileged mode, recorded on faults |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 no-fault load |
| req_user | input | 1 | User-mode access |
| req_csel | input | 2 | Context selector |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | 6 | Entry index |
| fill_vpn | input | 51 | Virtual page number (address bits 63:13) |
| fill_ctx | input | 13 | Entry context |
| fill_ppn | input | 28 | Physical page number (address bits 40:13) |
| fill_size | input | 2 | Page-size code |
| fill_valid | input | 1 | Valid attribute |
| fill_global | input | 1 | Global attribute |
| fill_priv | input | 1 | Privileged attribute |
| fill_writable | input | 1 | Write permission |
| fill_side_effect | input | 1 | Side-effect attribute |
| fill_nf_only | input | 1 | No-fault-only attribute |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit result |
| rsp_fault | output | 1 | Fault result |
| rsp_prot | output | 1 | Protection result |
| rsp_miss | output | 1 | Miss result |
| rsp_pa | output | 41 | Physical address on hit |
| rsp_wr_ok | output | 1 | Write permitted on hit |
| rsp_was_used | output | 1 | Used bit before this hit |
| fsr_o | output | 10 | Fault status register |
| far_o | output | 64 | Fault address register |
| tagacc_o | output | 64 | Tag-access register |

## Verification
The bench places entries of all four page sizes next to each other. It probes addresses just inside and just outside each page. A design that took the mask from a fixed size, or from the wrong entry, would hit or miss at the wrong boundary and would merge the wrong bits into the physical address.

Two global entries cover the same page, to catch a priority encoder that picks the highest index. A no-fault-only, non-writable entry is stored to, to catch a protection result that is not suppressed by a real fault. A fault that follows another fault shows whether overflow is set. A miss that follows the faults must leave the status and fault address untouched while the tag-access register still changes. A repeated hit and a refill expose a used bit that never sets or never clears.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 64;
  localparam int PA_W   = 41;
  localparam int CTX_W  = 13;
  localparam int PG_LSB = 13;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int PPN_W  = PA_W - PG_LSB;
  localparam int FSR_W  = 10;

  localparam int FB_VALID = 0;
  localparam int FB_OVF   = 1;
  localparam int FB_PRIVM = 2;
  localparam int FB_CTX   = 3;
  localparam int FB_STORE = 5;
  localparam int FB_NFLD  = 6;
  localparam int FB_PRIV  = 7;
  localparam int FB_SIDE  = 8;
  localparam int FB_NFO   = 9;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_NFLOAD = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {CS_PRI = 2'd0, CS_SEC = 2'd1, CS_NUC = 2'd2, CS_NUC2 = 2'd3} csel_e;

  typedef struct packed {
    logic             valid;
    logic             glob;
    logic             priv;
    logic             wr;
    logic             side;
    logic             nfo;
    logic [1:0]       size;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic [CTX_W-1:0] ctx;
  } ent_t;

  // Page-number mask: ones where the bit takes part in the compare.
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      2'd0:    m = '1;
      2'd1:    m[2:0] = '0;
      2'd2:    m[5:0] = '0;
      default: m[8:0] = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  ent_t          fill_ent,
  input  logic          hit_set,
  input  logic [IW-1:0] hit_idx,
  output ent_t          ents_o [N],
  output logic [N-1:0]  used_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    ent_t ent_q;
    logic used_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q.valid <= 1'b0;
        used_q      <= 1'b0;
      end else if (fill_en && fill_idx == IW'(i)) begin
        ent_q  <= fill_ent;
        used_q <= 1'b0;
      end else if (hit_set && hit_idx == IW'(i)) begin
        used_q <= 1'b1;
      end
    end
    assign ents_o[i] = ent_q;
    assign used_o[i] = used_q;
  end

  // R9: a freshly filled entry starts unused
  assert_fill_clears_used_R9: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> !used_o[$past(fill_idx)]);
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam import tlb_pkg::*; #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  ent_t             ents [N],
  input  logic [VPN_W-1:0] vpn,
  input  logic [CTX_W-1:0] ctx,
  output logic             hit_any,
  output logic [IW-1:0]    hit_idx
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VPN_W-1:0] m;
    assign m = vpn_mask(ents[i].size);
    assign match[i] = ents[i].valid && (((ents[i].vpn ^ vpn) & m) == '0)
                      && (ents[i].glob || ents[i].ctx == ctx);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end
  assign hit_any = |match;

  // R4: the chosen entry matches and no lower entry does
  always_comb begin
    if (hit_any) begin
      assert_lowest_wins_R4: assert (match[hit_idx] && ((match & ((N'(1) << hit_idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/tlb_fault_regs.sv
module tlb_fault_regs import tlb_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_fault,
  input  logic             ev_miss,
  input  logic             pr,
  input  logic [1:0]       ctx_kind,
  input  logic             is_store,
  input  logic             is_nfld,
  input  logic [2:0]       ftype,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic [FSR_W-1:0] fsr_o,
  output logic [VA_W-1:0]  far_o,
  output logic [VA_W-1:0]  tagacc_o
);
  logic [FSR_W-1:0] fsr_nxt;

  always_comb begin
    fsr_nxt                     = '0;
    fsr_nxt[FB_VALID]           = 1'b1;
    fsr_nxt[FB_OVF]             = fsr_o[FB_VALID];
    fsr_nxt[FB_PRIVM]           = pr;
    fsr_nxt[FB_CTX+1:FB_CTX]    = ctx_kind;
    fsr_nxt[FB_STORE]           = is_store;
    fsr_nxt[FB_NFLD]            = is_nfld;
    fsr_nxt[FB_PRIV]            = ftype[0];
    fsr_nxt[FB_SIDE]            = ftype[1];
    fsr_nxt[FB_NFO]             = ftype[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_o    <= '0;
      far_o    <= '0;
      tagacc_o <= '0;
    end else begin
      if (ev_fault) begin
        fsr_o <= fsr_nxt;
        far_o <= va;
      end
      if (ev_fault || ev_miss) tagacc_o <= {va[VA_W-1:PG_LSB], ctx};
    end
  end

  assert_miss_keeps_status_R8: assert property (@(posedge clk) disable iff (rst)
    ev_miss |=> ($stable(fsr_o) && $stable(far_o)));
  assert_fault_sets_valid_R7: assert property (@(posedge clk) disable iff (rst)
    ev_fault |=> fsr_o[FB_VALID]);
  assert_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_fault && fsr_o[FB_VALID]) |=> fsr_o[FB_OVF]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
  parameter int N_ENTRIES = 64,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlat_en,
  input  logic             priv_mode,
  input  logic [CTX_W-1:0] pri_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic [1:0]       req_csel,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_size,
  input  logic             fill_valid,
  input  logic             fill_global,
  input  logic             fill_priv,
  input  logic             fill_writable,
  input  logic             fill_side_effect,
  input  logic             fill_nf_only,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_prot,
  output logic             rsp_miss,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_wr_ok,
  output logic             rsp_was_used,
  output logic [FSR_W-1:0] fsr_o,
  output logic [VA_W-1:0]  far_o,
  output logic [VA_W-1:0]  tagacc_o
);
  ent_t                 ents [N_ENTRIES];
  logic [N_ENTRIES-1:0] used;
  ent_t                 fill_ent;
  ent_t                 sel;
  logic [CTX_W-1:0]     ctx;
  logic [1:0]           ctx_kind;
  logic                 hit_any;
  logic [IW-1:0]        hit_idx;
  logic [VPN_W-1:0]     m;
  logic [PPN_W-1:0]     ppn_out;
  logic                 f_priv, f_side, f_nfo, any_f, prot;
  logic                 go, ev_fault, ev_miss, ev_ok;
  logic                 mapped_q;
  acc_e                 kind;

  assign kind = acc_e'(req_kind);

  assign fill_ent = '{valid: fill_valid, glob: fill_global, priv: fill_priv,
                      wr: fill_writable, side: fill_side_effect, nfo: fill_nf_only,
                      size: fill_size, vpn: fill_vpn, ppn: fill_ppn, ctx: fill_ctx};

  always_comb begin
    case (csel_e'(req_csel))
      CS_PRI:  begin ctx = pri_ctx; ctx_kind = 2'd0; end
      CS_SEC:  begin ctx = sec_ctx; ctx_kind = 2'd1; end
      default: begin ctx = '0;      ctx_kind = 2'd2; end
    endcase
  end

  tlb_store #(.N(N_ENTRIES), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_idx(fill_idx), .fill_ent(fill_ent),
    .hit_set(ev_ok), .hit_idx(hit_idx), .ents_o(ents), .used_o(used));

  tlb_cam #(.N(N_ENTRIES), .IW(IW)) u_cam (
    .ents(ents), .vpn(req_va[VA_W-1:PG_LSB]), .ctx(ctx),
    .hit_any(hit_any), .hit_idx(hit_idx));

  assign sel     = ents[hit_idx];
  assign m       = vpn_mask(sel.size);
  assign ppn_out = (sel.ppn & m[PPN_W-1:0]) | (req_va[PA_W-1:PG_LSB] & ~m[PPN_W-1:0]);

  assign f_priv = sel.priv && req_user;
  assign f_side = (kind == ACC_NFLOAD) && sel.side;
  assign f_nfo  = (kind != ACC_NFLOAD) && sel.nfo;
  assign any_f  = f_priv || f_side || f_nfo;
  assign prot   = (kind == ACC_STORE) && !sel.wr && !any_f;

  assign go       = req_valid && xlat_en;
  assign ev_miss  = go && !hit_any;
  assign ev_fault = go && hit_any && (any_f || prot);
  assign ev_ok    = go && hit_any && !any_f && !prot;

  tlb_fault_regs u_fregs (
    .clk(clk), .rst(rst), .ev_fault(ev_fault), .ev_miss(ev_miss), .pr(priv_mode),
    .ctx_kind(ctx_kind), .is_store(kind == ACC_STORE), .is_nfld(kind == ACC_NFLOAD),
    .ftype({f_nfo, f_side, f_priv}), .va(req_va), .ctx(ctx),
    .fsr_o(fsr_o), .far_o(far_o), .tagacc_o(tagacc_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_prot     <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_pa       <= '0;
      rsp_wr_ok    <= 1'b0;
      rsp_was_used <= 1'b0;
      mapped_q     <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= req_valid && (!xlat_en || ev_ok);
      rsp_fault    <= ev_fault && any_f;
      rsp_prot     <= ev_fault && prot;
      rsp_miss     <= ev_miss;
      rsp_pa       <= xlat_en ? {ppn_out, {PG_LSB{1'b0}}} : req_va[PA_W-1:0];
      rsp_wr_ok    <= xlat_en ? sel.wr : 1'b1;
      rsp_was_used <= xlat_en && used[hit_idx];
      mapped_q     <= xlat_en;
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_prot, rsp_miss}) == 1);
  assert_pa_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && mapped_q) |-> rsp_pa[PG_LSB-1:0] == '0);
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, xlat_en, priv_mode;
  logic [12:0] pri_ctx, sec_ctx;
  logic        req_valid, req_user;
  logic [63:0] req_va;
  logic [1:0]  req_kind, req_csel;
  logic        fill_en;
  logic [5:0]  fill_idx;
  logic [50:0] fill_vpn;
  logic [12:0] fill_ctx;
  logic [27:0] fill_ppn;
  logic [1:0]  fill_size;
  logic        fill_valid, fill_global, fill_priv, fill_writable, fill_side_effect, fill_nf_only;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_prot, rsp_miss, rsp_wr_ok, rsp_was_used;
  logic [40:0] rsp_pa;
  logic [9:0]  fsr_o;
  logic [63:0] far_o, tagacc_o;

  int checks = 0;
  int fails  = 0;

  tlb_xlate u_dut (.*);

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  kind;
    logic        user;
    logic [1:0]  csel;
    logic [1:0]  cls;   // 0 hit, 1 fault, 2 prot, 3 miss
    logic [40:0] pa;
    logic        wr;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_1000_0000_2abc, 2'd0, 1'b0, 2'd0, 2'd0, 41'h001_2345_6000, 1'b1, 8'd1}, // R1 8K
    '{64'h0000_1000_0000_2abc, 2'd1, 1'b1, 2'd0, 2'd0, 41'h001_2345_6000, 1'b1, 8'd2}, // R2
    '{64'h0000_1000_0000_2abc, 2'd0, 1'b0, 2'd1, 2'd3, 41'h0,             1'b0, 8'd2}, // R2 ctx mismatch
    '{64'h0000_1000_0000_4000, 2'd0, 1'b0, 2'd0, 2'd3, 41'h0,             1'b0, 8'd1}, // R1 8K edge
    '{64'h0000_2000_0023_4567, 2'd0, 1'b0, 2'd1, 2'd0, 41'h000_8023_4000, 1'b0, 8'd1}, // R1 4M global
    '{64'h0000_2000_003f_ffff, 2'd0, 1'b0, 2'd2, 2'd0, 41'h000_803f_e000, 1'b0, 8'd3}, // R3 nucleus
    '{64'h0000_2000_0040_0000, 2'd0, 1'b0, 2'd0, 2'd3, 41'h0,             1'b0, 8'd1}, // R1 4M edge
    '{64'h0000_2000_0023_4567, 2'd1, 1'b0, 2'd0, 2'd2, 41'h0,             1'b0, 8'd6}, // R6 prot
    '{64'h0000_3000_0001_a123, 2'd0, 1'b0, 2'd1, 2'd0, 41'h004_0000_a000, 1'b1, 8'd3}, // R3 secondary
    '{64'h0000_3000_0001_a123, 2'd0, 1'b0, 2'd0, 2'd3, 41'h0,             1'b0, 8'd3}, // R3 primary
    '{64'h0000_3000_0002_0000, 2'd0, 1'b0, 2'd1, 2'd3, 41'h0,             1'b0, 8'd1}, // R1 64K edge
    '{64'h0000_3000_0001_a123, 2'd0, 1'b1, 2'd1, 2'd1, 41'h0,             1'b0, 8'd5}, // R5 priv
    '{64'h0000_4000_000f_ffff, 2'd0, 1'b0, 2'd2, 2'd1, 41'h0,             1'b0, 8'd5}, // R5 nfo
    '{64'h0000_4000_000f_ffff, 2'd2, 1'b0, 2'd2, 2'd1, 41'h0,             1'b0, 8'd5}, // R5 side
    '{64'h0000_4000_000f_ffff, 2'd1, 1'b0, 2'd3, 2'd1, 41'h0,             1'b0, 8'd6}, // R6 suppressed
    '{64'h0000_4000_000f_ffff, 2'd0, 1'b0, 2'd0, 2'd3, 41'h0,             1'b0, 8'd3}, // R3 ctx 5 vs 0
    '{64'h0000_5000_0000_0100, 2'd0, 1'b0, 2'd0, 2'd0, 41'h000_0000_a000, 1'b1, 8'd4}, // R4 lowest
    '{64'h0000_6000_0000_0000, 2'd0, 1'b0, 2'd0, 2'd3, 41'h0,             1'b0, 8'd2}, // R2 invalid
    '{64'h0000_7000_000c_5678, 2'd0, 1'b0, 2'd0, 2'd0, 41'h1f0_0004_4000, 1'b0, 8'd1}  // R1 512K
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input int idx, input logic [63:0] va, input logic [12:0] c,
                      input logic [40:0] pa, input logic [1:0] sz, input logic v,
                      input logic g, input logic p, input logic w, input logic s, input logic n);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 6'(idx); fill_vpn = va[63:13]; fill_ctx = c;
    fill_ppn = pa[40:13]; fill_size = sz; fill_valid = v; fill_global = g;
    fill_priv = p; fill_writable = w; fill_side_effect = s; fill_nf_only = n;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] k, input logic u, input logic [1:0] cs);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_kind = k; req_user = u; req_csel = cs;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [2:0] cls_of();
    return rsp_hit ? 3'd0 : rsp_fault ? 3'd1 : rsp_prot ? 3'd2 : rsp_miss ? 3'd3 : 3'd7;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0]  fsr_s;
    logic [63:0] tag_s;
    rst = 1'b1; xlat_en = 1'b1; priv_mode = 1'b0; pri_ctx = 13'd5; sec_ctx = 13'd7;
    req_valid = 1'b0; req_va = '0; req_kind = '0; req_user = 1'b0; req_csel = '0;
    fill_en = 1'b0; fill_idx = '0; fill_vpn = '0; fill_ctx = '0; fill_ppn = '0; fill_size = '0;
    fill_valid = 1'b0; fill_global = 1'b0; fill_priv = 1'b0; fill_writable = 1'b0;
    fill_side_effect = 1'b0; fill_nf_only = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 reset fsr", 64'(fsr_o), 64'd0);
    chk("R11 reset far", far_o, 64'd0);
    chk("R11 reset tagacc", tagacc_o, 64'd0);

    //   idx va                      ctx  pa                sz   v g p w s n
    fill(0,  64'h0000_1000_0000_2000, 13'd5, 41'h001_2345_6000, 2'd0, 1,0,0,1,0,0);
    fill(1,  64'h0000_2000_0000_0000, 13'd0, 41'h000_8000_0000, 2'd3, 1,1,0,0,0,0);
    fill(2,  64'h0000_3000_0001_0000, 13'd7, 41'h004_0000_0000, 2'd1, 1,0,1,1,0,0);
    fill(3,  64'h0000_4000_0008_0000, 13'd0, 41'h100_0000_0000, 2'd2, 1,0,1,0,1,1);
    fill(4,  64'h0000_7000_0008_0000, 13'd0, 41'h1f0_0007_0000, 2'd2, 1,1,0,0,0,0);
    fill(10, 64'h0000_5000_0000_0000, 13'd0, 41'h000_0000_a000, 2'd0, 1,1,0,1,0,0);
    fill(20, 64'h0000_5000_0000_0000, 13'd0, 41'h000_0000_b000, 2'd0, 1,1,0,1,0,0);
    fill(30, 64'h0000_6000_0000_0000, 13'd5, 41'h000_0000_c000, 2'd0, 0,1,0,1,0,0);

    // R9 used bit
    lookup(64'h0000_1000_0000_2000, 2'd0, 1'b0, 2'd0);
    chk("R9 first hit was_used", 64'(rsp_was_used), 64'd0);
    lookup(64'h0000_1000_0000_2000, 2'd0, 1'b0, 2'd0);
    chk("R9 second hit was_used", 64'(rsp_was_used), 64'd1);
    chk("R8 hits leave fsr", 64'(fsr_o), 64'd0);
    fill(0,  64'h0000_1000_0000_2000, 13'd5, 41'h001_2345_6000, 2'd0, 1,0,0,1,0,0);
    lookup(64'h0000_1000_0000_2000, 2'd0, 1'b0, 2'd0);
    chk("R9 refill clears used", 64'(rsp_was_used), 64'd0);

    // R7 first fault: user load to privileged 64K entry via secondary
    lookup(64'h0000_3000_0001_a123, 2'd0, 1'b1, 2'd1);
    chk("R5 priv fault class", 64'(cls_of()), 64'd1);
    chk("R7 fsr first fault", 64'(fsr_o), 64'h089);
    chk("R7 far first fault", far_o, 64'h0000_3000_0001_a123);
    chk("R8 tagacc first fault", tagacc_o, 64'h0000_3000_0001_a007);

    // R5 R7 two fault bits, overflow, privileged mode, nucleus
    priv_mode = 1'b1;
    lookup(64'h0000_4000_000f_ffff, 2'd2, 1'b1, 2'd2);
    chk("R5 multi fault class", 64'(cls_of()), 64'd1);
    chk("R7 fsr overflow multi", 64'(fsr_o), 64'h1d7);
    chk("R8 tagacc nucleus", tagacc_o, 64'h0000_4000_000f_e000);
    priv_mode = 1'b0;

    // R8 miss keeps fsr/far, updates tag-access
    lookup(64'h0000_6000_0000_0123, 2'd0, 1'b0, 2'd0);
    chk("R8 miss class", 64'(cls_of()), 64'd3);
    chk("R8 miss fsr kept", 64'(fsr_o), 64'h1d7);
    chk("R8 miss far kept", far_o, 64'h0000_4000_000f_ffff);
    chk("R8 miss tagacc", tagacc_o, 64'h0000_6000_0000_0005);

    // R6 protection status
    lookup(64'h0000_2000_0023_4567, 2'd1, 1'b0, 2'd0);
    chk("R6 prot class", 64'(cls_of()), 64'd2);
    chk("R6 R7 prot fsr", 64'(fsr_o), 64'h023);
    chk("R7 prot far", far_o, 64'h0000_2000_0023_4567);
    chk("R8 prot tagacc", tagacc_o, 64'h0000_2000_0023_4005);

    // table walk
    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].kind, VECS[i].user, VECS[i].csel);
      checks++;
      if (!rsp_valid || cls_of() != {1'b0, VECS[i].cls}) begin
        fails++;
        $display("FAIL R%0d vec %0d class act=%0d exp=%0d", VECS[i].rq, i, cls_of(), VECS[i].cls);
      end
      if (VECS[i].cls == 2'd0) begin
        checks++;
        if (rsp_pa !== VECS[i].pa || rsp_wr_ok !== VECS[i].wr) begin
          fails++;
          $display("FAIL R%0d vec %0d pa/wr act=%h/%0d exp=%h/%0d", VECS[i].rq, i,
                   rsp_pa, rsp_wr_ok, VECS[i].pa, VECS[i].wr);
        end
      end
    end

    // R10 translation off
    fsr_s = fsr_o; tag_s = tagacc_o;
    xlat_en = 1'b0;
    lookup(64'hffff_ffff_ffff_ffff, 2'd1, 1'b1, 2'd0);
    chk("R10 off class", 64'(cls_of()), 64'd0);
    chk("R10 off pa", 64'(rsp_pa), 64'h1ff_ffff_ffff);
    chk("R10 off wr", 64'(rsp_wr_ok), 64'd1);
    lookup(64'h0000_6000_0000_0123, 2'd0, 1'b0, 2'd0);
    chk("R10 off unmapped pa", 64'(rsp_pa), 64'h123);
    chk("R10 off fsr kept", 64'(fsr_o), 64'(fsr_s));
    chk("R10 off tagacc kept", tagacc_o, tag_s);
    xlat_en = 1'b1;

    // R11 idle cycle
    @(negedge clk);
    chk("R11 idle no response", 64'(rsp_valid), 64'd0);

    // R11 reset invalidates entries and clears registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset fsr again", 64'(fsr_o), 64'd0);
    lookup(64'h0000_1000_0000_2000, 2'd0, 1'b0, 2'd0);
    chk("R11 entries invalid after reset", 64'(cls_of()), 64'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule